// File: doc/BRIEF.md
# Mailbox Protocol Discovery Table

This block sits above a mailbox request/response engine. When `start` is pulsed it clears its table and runs a discovery walk. It sends discovery requests to the engine, beginning at index 0. It stores the vendor/type pair carried by each response and follows the next-index field until that field reads zero. The walk ends in a done state, or in an error state that carries a code naming the cause.

Once the walk has finished, the block answers two kinds of question. The first is a lookup port that tells whether a (vendor ID, type) pair is supported. The second is a submit gate that admits or rejects a user request. A request is rejected as invalid if it is unsupported or badly sized. It is rejected with an I/O error if the mailbox is marked dead. The discovery protocol itself counts as supported even when no entry in the table names it.

Top module: `mbx_proto_catalog`

## Requirements
- R1: Every discovery request carries vendor ID 0x0001 and object type 0. Its single payload dword holds the current index in bits 7:0, and all other payload bits are zero. While `eng_req_ready` is low, the request stays valid and its payload does not change.
- R2: The first request after a start uses index 0. Each later request uses the next index taken from bits 31:24 of the previous response. When a response's next index is zero, the walk ends with `cat_done` high and `cat_err` low.
- R3: Each response holds the vendor ID in bits 15:0 and the protocol type in bits 23:16. After the walk, each such pair reads as supported on the lookup port. A pair that mixes the vendor of one entry with the type of another does not.
- R4: A response whose byte count is not 4 ends the walk with `cat_err` high and `cat_err_code` = 1.
- R5: A response that has the engine error flag set ends the walk with `cat_err` high and `cat_err_code` = 3.
- R6: The table holds DEPTH entries. A walk that returns exactly DEPTH entries completes normally. A response that would add entry DEPTH+1 ends the walk with `cat_err` high and `cat_err_code` = 2.
- R7: `lk_hit` is combinational. It is 0 whenever `cat_done` is low, which covers the time during a walk and after a failed walk.
- R8: When `cat_done` is high, the pair (0x0001, 0) always reads as supported, even if no response named it.
- R9: When `sub_valid` is high, `sub_inval` is raised in three cases: the pair is not supported by the R7/R8 rules, `sub_req_bytes` is not a multiple of 4, or `sub_rsp_bytes` is below 4. At most one of `sub_ok`, `sub_inval` and `sub_ioerr` is high, and all three are low when `sub_valid` is low.
- R10: A request that is not invalid is answered with `sub_ioerr` while `mbx_dead` is high, and with `sub_ok` otherwise. An invalid request still gets `sub_inval` while the mailbox is dead.
- R11: A start pulse given while no walk is running empties the table and restarts the walk from index 0. A start pulse given during a walk is ignored.
- R12: After reset, `cat_done`, `cat_err` and `eng_req_valid` are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a discovery walk |
| mbx_dead | input | 1 | Mailbox has been marked unusable |
| eng_req_valid | output | 1 | Discovery request to the engine is valid |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_req_vid | output | 16 | Request vendor ID |
| eng_req_type | output | 8 | Request object type |
| eng_req_data | output | 32 | Request payload dword |
| eng_rsp_valid | input | 1 | Engine response strobe |
| eng_rsp_err | input | 1 | Engine reports a failed exchange |
| eng_rsp_bytes | input | 16 | Response payload size in bytes |
| eng_rsp_data | input | 32 | Response payload dword |
| cat_done | output | 1 | Walk finished successfully |
| cat_err | output | 1 | Walk ended with an error |
| cat_err_code | output | 2 | 0 none, 1 length, 2 overflow, 3 engine |
| lk_vid | input | 16 | Lookup vendor ID |
| lk_type | input | 8 | Lookup type |
| lk_hit | output | 1 | Lookup pair supported |
| sub_valid | input | 1 | Submission presented |
| sub_vid | input | 16 | Submission vendor ID |
| sub_type | input | 8 | Submission type |
| sub_req_bytes | input | 16 | Request size in bytes |
| sub_rsp_bytes | input | 16 | Response buffer size in bytes |
| sub_ok | output | 1 | Submission admitted |
| sub_inval | output | 1 | Submission rejected as invalid |
| sub_ioerr | output | 1 | Submission rejected, mailbox dead |

## Verification
The bench builds the block with DEPTH = 4 and leaves the field widths at their defaults. With that depth, a four-entry chain lands exactly on the table limit, and a five-entry chain crosses it, so both sides of the overflow boundary are reached with short walks. The engine model stalls `eng_req_ready` on alternate cycles. This exercises request holding, and it also makes the walk last long enough to test a restart attempt while the walk is running.

// File: rtl/mbx_cat_pkg.sv
// Shared types for the protocol discovery table.
// Assumes nothing beyond the importing modules agreeing on these encodings.
package mbx_cat_pkg;
    typedef enum logic [1:0] {
        CAT_OK   = 2'd0,
        CAT_ELEN = 2'd1,
        CAT_EOVF = 2'd2,
        CAT_EENG = 2'd3
    } cat_err_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_SEND,
        W_WAIT,
        W_DONE,
        W_FAIL
    } walk_st_e;

    localparam int DWORD_BYTES = 4;
endpackage

// File: rtl/mbx_cat_walker.sv
// Discovery walker: issues one discovery request per index, checks each
// response, hands good entries to the store and follows the next-index chain.
// Assumes the engine returns exactly one response per accepted request.
module mbx_cat_walker
    import mbx_cat_pkg::*;
#(
    parameter int VID_W  = 16,
    parameter int TYPE_W = 8,
    parameter int IDX_W  = 8,
    parameter int SZ_W   = 16,
    localparam int DW    = VID_W + TYPE_W + IDX_W,
    localparam int ENT_W = VID_W + TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [VID_W-1:0]  req_vid,
    output logic [TYPE_W-1:0] req_type,
    output logic [DW-1:0]     req_data,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [SZ_W-1:0]   rsp_bytes,
    input  logic [DW-1:0]     rsp_data,
    input  logic              tbl_full,
    output logic              tbl_clr,
    output logic              wr_en,
    output logic [ENT_W-1:0]  wr_entry,
    output logic              done,
    output logic              err,
    output cat_err_e          err_code
);
    walk_st_e         st;
    logic [IDX_W-1:0] idx;

    // Split the response dword into its fields.
    logic [VID_W-1:0]  r_vid;
    logic [TYPE_W-1:0] r_type;
    logic [IDX_W-1:0]  r_next;
    logic              len_ok;
    logic              idle_like;

    // Field extraction and qualification of the current response.
    always_comb begin
        r_vid     = rsp_data[VID_W-1:0];
        r_type    = rsp_data[VID_W +: TYPE_W];
        r_next    = rsp_data[ENT_W +: IDX_W];
        len_ok    = (rsp_bytes == SZ_W'(DWORD_BYTES));
        idle_like = (st == W_IDLE) || (st == W_DONE) || (st == W_FAIL);
    end

    // Walk sequencing: start, send, wait, then finish or fail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= W_IDLE;
            idx      <= '0;
            err_code <= CAT_OK;
        end else begin
            case (st)
                W_SEND: if (req_ready) st <= W_WAIT;
                W_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            st       <= W_FAIL;
                            err_code <= CAT_EENG;
                        end else if (!len_ok) begin
                            st       <= W_FAIL;
                            err_code <= CAT_ELEN;
                        end else if (tbl_full) begin
                            st       <= W_FAIL;
                            err_code <= CAT_EOVF;
                        end else if (r_next == '0) begin
                            st <= W_DONE;
                        end else begin
                            idx <= r_next;
                            st  <= W_SEND;
                        end
                    end
                end
                default: begin
                    if (start) begin
                        st       <= W_SEND;
                        idx      <= '0;
                        err_code <= CAT_OK;
                    end
                end
            endcase
        end
    end

    // Request fields, store write strobe and status outputs.
    always_comb begin
        req_valid = (st == W_SEND);
        req_vid   = VID_W'(1);
        req_type  = '0;
        req_data  = DW'(idx);
        tbl_clr   = start && idle_like;
        wr_en     = (st == W_WAIT) && rsp_valid && !rsp_err && len_ok && !tbl_full;
        wr_entry  = {r_vid, r_type};
        done      = (st == W_DONE);
        err       = (st == W_FAIL);
    end

    a_r2_first_index: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clr |=> (req_valid && req_data[IDX_W-1:0] == '0));
    a_r1_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data)));
    a_r4_len_fails: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == W_WAIT) && rsp_valid && !rsp_err && !len_ok) |=> (err && err_code == CAT_ELEN));
    a_r12_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
endmodule

// File: rtl/mbx_cat_store.sv
// Entry store: appends packed (vendor, type) entries in sequential slots
// and exposes the whole table with a per-slot valid mask.
// Assumes the writer never writes while full.
module mbx_cat_store #(
    parameter int DEPTH  = 8,
    parameter int ENT_W  = 24,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic [ENT_W-1:0]       wr_entry,
    output logic                   full,
    output logic [DEPTH*ENT_W-1:0] tbl_flat,
    output logic [DEPTH-1:0]       tbl_valid
);
    logic [CNT_W-1:0] cnt;

    // Fill counter: cleared on a new walk, bumped per stored entry.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (wr_en) cnt <= cnt + 1'b1;
    end

    assign full = (cnt == CNT_W'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [ENT_W-1:0] slot;
        // Slot register: captures the entry when it is the next free slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                          slot <= '0;
            else if (wr_en && cnt == CNT_W'(i))  slot <= wr_entry;
        end
        assign tbl_flat[i*ENT_W +: ENT_W] = slot;
        assign tbl_valid[i] = (cnt > CNT_W'(i));
    end

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tbl_valid == '0));
endmodule

// File: rtl/mbx_cat_match.sv
// Lookup matcher: compares one query against every valid slot in parallel
// and treats the discovery pair as always present.
// Assumes enable is held low until the table is complete.
module mbx_cat_match #(
    parameter int DEPTH  = 8,
    parameter int VID_W  = 16,
    parameter int TYPE_W = 8,
    localparam int ENT_W = VID_W + TYPE_W
) (
    input  logic                   enable,
    input  logic [VID_W-1:0]       q_vid,
    input  logic [TYPE_W-1:0]      q_type,
    input  logic [DEPTH*ENT_W-1:0] tbl_flat,
    input  logic [DEPTH-1:0]       tbl_valid,
    output logic                   hit
);
    logic [DEPTH-1:0] slot_hit;
    logic             is_disc;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign slot_hit[i] = tbl_valid[i] && (tbl_flat[i*ENT_W +: ENT_W] == {q_vid, q_type});
    end

    // Combine the discovery rule with the table comparison.
    always_comb begin
        is_disc = (q_vid == VID_W'(1)) && (q_type == '0);
        hit     = enable && (is_disc || (|slot_hit));
    end
endmodule

// File: rtl/mbx_cat_gate.sv
// Submission gate: classifies a presented request as admitted, invalid or
// refused because the mailbox is dead. Invalid takes precedence over dead.
// Assumes proto_hit comes from a matcher on the same vendor/type pair.
module mbx_cat_gate
    import mbx_cat_pkg::*;
#(
    parameter int SZ_W = 16
) (
    input  logic            sub_valid,
    input  logic            dead,
    input  logic            proto_hit,
    input  logic [SZ_W-1:0] req_bytes,
    input  logic [SZ_W-1:0] rsp_bytes,
    output logic            ok,
    output logic            inval,
    output logic            ioerr
);
    logic size_bad;

    // Size checks first, then the three-way verdict.
    always_comb begin
        size_bad = (req_bytes[1:0] != 2'b00) || (rsp_bytes < SZ_W'(DWORD_BYTES));
        inval    = sub_valid && (!proto_hit || size_bad);
        ioerr    = sub_valid && !inval && dead;
        ok       = sub_valid && !inval && !dead;
    end
endmodule

// File: rtl/mbx_proto_catalog.sv
// Top of the protocol discovery table: walker, store, two matchers
// (lookup port and submit gate) and the gate itself.
// Assumes a single engine behind the request/response port.
module mbx_proto_catalog
    import mbx_cat_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int VID_W  = 16,
    parameter int TYPE_W = 8,
    parameter int IDX_W  = 8,
    parameter int SZ_W   = 16,
    localparam int DW    = VID_W + TYPE_W + IDX_W,
    localparam int ENT_W = VID_W + TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mbx_dead,
    output logic              eng_req_valid,
    input  logic              eng_req_ready,
    output logic [VID_W-1:0]  eng_req_vid,
    output logic [TYPE_W-1:0] eng_req_type,
    output logic [DW-1:0]     eng_req_data,
    input  logic              eng_rsp_valid,
    input  logic              eng_rsp_err,
    input  logic [SZ_W-1:0]   eng_rsp_bytes,
    input  logic [DW-1:0]     eng_rsp_data,
    output logic              cat_done,
    output logic              cat_err,
    output logic [1:0]        cat_err_code,
    input  logic [VID_W-1:0]  lk_vid,
    input  logic [TYPE_W-1:0] lk_type,
    output logic              lk_hit,
    input  logic              sub_valid,
    input  logic [VID_W-1:0]  sub_vid,
    input  logic [TYPE_W-1:0] sub_type,
    input  logic [SZ_W-1:0]   sub_req_bytes,
    input  logic [SZ_W-1:0]   sub_rsp_bytes,
    output logic              sub_ok,
    output logic              sub_inval,
    output logic              sub_ioerr
);
    logic                   tbl_full;
    logic                   tbl_clr;
    logic                   wr_en;
    logic [ENT_W-1:0]       wr_entry;
    logic [DEPTH*ENT_W-1:0] tbl_flat;
    logic [DEPTH-1:0]       tbl_valid;
    logic                   sub_hit;
    cat_err_e               code;

    mbx_cat_walker #(.VID_W(VID_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W), .SZ_W(SZ_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(eng_req_valid), .req_ready(eng_req_ready),
        .req_vid(eng_req_vid), .req_type(eng_req_type), .req_data(eng_req_data),
        .rsp_valid(eng_rsp_valid), .rsp_err(eng_rsp_err),
        .rsp_bytes(eng_rsp_bytes), .rsp_data(eng_rsp_data),
        .tbl_full(tbl_full), .tbl_clr(tbl_clr),
        .wr_en(wr_en), .wr_entry(wr_entry),
        .done(cat_done), .err(cat_err), .err_code(code)
    );

    assign cat_err_code = code;

    mbx_cat_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(tbl_clr),
        .wr_en(wr_en), .wr_entry(wr_entry), .full(tbl_full),
        .tbl_flat(tbl_flat), .tbl_valid(tbl_valid)
    );

    mbx_cat_match #(.DEPTH(DEPTH), .VID_W(VID_W), .TYPE_W(TYPE_W)) u_lk_match (
        .enable(cat_done), .q_vid(lk_vid), .q_type(lk_type),
        .tbl_flat(tbl_flat), .tbl_valid(tbl_valid), .hit(lk_hit)
    );

    mbx_cat_match #(.DEPTH(DEPTH), .VID_W(VID_W), .TYPE_W(TYPE_W)) u_sub_match (
        .enable(cat_done), .q_vid(sub_vid), .q_type(sub_type),
        .tbl_flat(tbl_flat), .tbl_valid(tbl_valid), .hit(sub_hit)
    );

    mbx_cat_gate #(.SZ_W(SZ_W)) u_gate (
        .sub_valid(sub_valid), .dead(mbx_dead), .proto_hit(sub_hit),
        .req_bytes(sub_req_bytes), .rsp_bytes(sub_rsp_bytes),
        .ok(sub_ok), .inval(sub_inval), .ioerr(sub_ioerr)
    );

    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sub_ok, sub_inval, sub_ioerr}));
    a_r10_dead_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        sub_ok |-> !mbx_dead);
    a_r7_lookup_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !cat_done |-> !lk_hit);
endmodule

// File: tb/mbx_proto_catalog_bench.sv
`timescale 1ns/1ps
module mbx_proto_catalog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mbx_dead = 1'b0;
    logic        eng_req_valid;
    logic        eng_req_ready = 1'b0;
    logic [15:0] eng_req_vid;
    logic [7:0]  eng_req_type;
    logic [31:0] eng_req_data;
    logic        eng_rsp_valid = 1'b0;
    logic        eng_rsp_err = 1'b0;
    logic [15:0] eng_rsp_bytes = '0;
    logic [31:0] eng_rsp_data = '0;
    logic        cat_done, cat_err;
    logic [1:0]  cat_err_code;
    logic [15:0] lk_vid = '0;
    logic [7:0]  lk_type = '0;
    logic        lk_hit;
    logic        sub_valid = 1'b0;
    logic [15:0] sub_vid = '0;
    logic [7:0]  sub_type = '0;
    logic [15:0] sub_req_bytes = '0;
    logic [15:0] sub_rsp_bytes = '0;
    logic        sub_ok, sub_inval, sub_ioerr;

    always #2.5 clk = ~clk;

    mbx_proto_catalog #(.DEPTH(4)) u_mbx_proto_catalog (.*);

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] chain [256];
    int          bad_len_idx = -1;
    int          eng_err_idx = -1;
    bit          stall_mode = 1'b0;
    int          exp_q [$];
    int          rsp_cnt = 0;
    int          rsp_idx = 0;
    bit          done_flag = 1'b0;

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ent(input logic [15:0] v, input logic [7:0] t, input logic [7:0] nx);
        return {nx, t, v};
    endfunction

    // Engine model and request monitor: pops expected indices and answers.
    always @(negedge clk) begin
        if (!rst_n) begin
            eng_req_ready = 1'b0;
            eng_rsp_valid = 1'b0;
            rsp_cnt = 0;
        end else begin
            eng_rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    eng_rsp_valid = 1'b1;
                    eng_rsp_err   = (rsp_idx == eng_err_idx);
                    eng_rsp_bytes = (rsp_idx == bad_len_idx) ? 16'd8 : 16'd4;
                    eng_rsp_data  = chain[rsp_idx];
                end
            end
            eng_req_ready = stall_mode ? ~eng_req_ready : 1'b1;
            if (eng_req_valid && eng_req_ready) begin
                int exp_idx;
                exp_idx = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                chk(eng_req_data == 32'(exp_idx), "R2 request index", eng_req_data, exp_idx);
                chk(eng_req_vid == 16'h0001 && eng_req_type == 8'h00, "R1 request header",
                    {eng_req_vid, eng_req_type}, 24'h000100);
                rsp_idx = int'(eng_req_data[7:0]);
                rsp_cnt = 3;
            end
        end
    end

    task automatic run_walk(input bit exp_done, input int exp_code, input string req);
        int waited;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        waited = 0;
        while (!(cat_done || cat_err) && waited < 400) begin
            @(negedge clk);
            waited++;
        end
        chk(cat_done == exp_done && cat_err == !exp_done, req, {cat_done, cat_err}, {exp_done, !exp_done});
        chk(cat_err_code == 2'(exp_code), req, cat_err_code, exp_code);
        chk(exp_q.size() == 0, {req, " request count"}, exp_q.size(), 0);
    endtask

    task automatic lookup(input logic [15:0] v, input logic [7:0] t, input bit exp, input string req);
        @(negedge clk);
        lk_vid = v;
        lk_type = t;
        #1;
        chk(lk_hit == exp, req, lk_hit, exp);
    endtask

    task automatic submit(input bit vld, input logic [15:0] v, input logic [7:0] t,
                          input int rq, input int rs, input bit dead,
                          input logic [2:0] exp, input string req);
        @(negedge clk);
        sub_valid = vld;
        sub_vid = v;
        sub_type = t;
        sub_req_bytes = 16'(rq);
        sub_rsp_bytes = 16'(rs);
        mbx_dead = dead;
        #1;
        chk({sub_ok, sub_inval, sub_ioerr} == exp, req, {sub_ok, sub_inval, sub_ioerr}, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) chain[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!cat_done && !cat_err && !eng_req_valid, "R12 reset state",
            {cat_done, cat_err, eng_req_valid}, 0);
        lookup(16'h0001, 8'h00, 1'b0, "R7 lookup blocked after reset");

        // R1/R2/R7/R11: three-entry chain with a stalled engine
        chain[0] = ent(16'h0001, 8'h00, 8'h03);
        chain[3] = ent(16'h1E98, 8'h02, 8'h07);
        chain[7] = ent(16'h1234, 8'h05, 8'h00);
        stall_mode = 1'b1;
        exp_q.push_back(0); exp_q.push_back(3); exp_q.push_back(7);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
        lk_vid = 16'h0001; lk_type = 8'h00; #1;
        chk(!lk_hit && !cat_done, "R7 lookup blocked during walk", lk_hit, 0);
        @(negedge clk) start = 1'b1;   // R11: ignored mid-walk
        @(negedge clk) start = 1'b0;
        begin
            int w = 0;
            while (!(cat_done || cat_err) && w < 400) begin @(negedge clk); w++; end
        end
        chk(cat_done && !cat_err, "R2 chain walk done", {cat_done, cat_err}, 2'b10);
        chk(exp_q.size() == 0, "R11 no restart mid-walk", exp_q.size(), 0);
        stall_mode = 1'b0;

        // R3/R8: lookups
        lookup(16'h1E98, 8'h02, 1'b1, "R3 entry one present");
        lookup(16'h1234, 8'h05, 1'b1, "R3 entry two present");
        lookup(16'h1234, 8'h02, 1'b0, "R3 crossed pair absent");
        lookup(16'h1E98, 8'h05, 1'b0, "R3 crossed pair absent");
        lookup(16'h0001, 8'h00, 1'b1, "R8 discovery pair");

        // R9/R10: submit gate
        submit(1'b0, 16'h1234, 8'h05, 8, 4, 1'b0, 3'b000, "R9 idle gate quiet");
        submit(1'b1, 16'h1234, 8'h05, 8, 4, 1'b0, 3'b100, "R9 good submission");
        submit(1'b1, 16'h1234, 8'h05, 6, 4, 1'b0, 3'b010, "R9 odd request size");
        submit(1'b1, 16'h1234, 8'h05, 8, 3, 1'b0, 3'b010, "R9 short response buffer");
        submit(1'b1, 16'h5555, 8'h01, 8, 4, 1'b0, 3'b010, "R9 unsupported protocol");
        submit(1'b1, 16'h1234, 8'h05, 0, 4, 1'b1, 3'b001, "R10 dead mailbox");
        submit(1'b1, 16'h5555, 8'h01, 8, 4, 1'b1, 3'b010, "R10 invalid wins over dead");
        submit(1'b0, 16'h0000, 8'h00, 0, 0, 1'b0, 3'b000, "R9 idle gate quiet");

        // R8/R11: new walk without the discovery entry clears the old table
        chain[0] = ent(16'h00AA, 8'h01, 8'h00);
        exp_q.push_back(0);
        run_walk(1'b1, 0, "R11 rewalk");
        lookup(16'h0001, 8'h00, 1'b1, "R8 discovery pair not in table");
        lookup(16'h00AA, 8'h01, 1'b1, "R3 new entry present");
        lookup(16'h1234, 8'h05, 1'b0, "R11 old entry cleared");

        // R4: wrong response size
        chain[0] = ent(16'h0001, 8'h00, 8'h02);
        chain[2] = ent(16'h0077, 8'h09, 8'h00);
        bad_len_idx = 2;
        exp_q.push_back(0); exp_q.push_back(2);
        run_walk(1'b0, 1, "R4 length error");
        lookup(16'h0001, 8'h00, 1'b0, "R7 lookup blocked after failure");
        bad_len_idx = -1;

        // R5: engine error
        eng_err_idx = 0;
        exp_q.push_back(0);
        run_walk(1'b0, 3, "R5 engine error");
        eng_err_idx = -1;

        // R6: exactly DEPTH entries
        chain[0] = ent(16'h0001, 8'h00, 8'h01);
        chain[1] = ent(16'h0011, 8'h01, 8'h02);
        chain[2] = ent(16'h0022, 8'h02, 8'h03);
        chain[3] = ent(16'h0033, 8'h03, 8'h00);
        for (int i = 0; i < 4; i++) exp_q.push_back(i);
        run_walk(1'b1, 0, "R6 full table completes");
        lookup(16'h0033, 8'h03, 1'b1, "R6 last slot usable");

        // R6: one entry too many
        chain[3] = ent(16'h0033, 8'h03, 8'h04);
        chain[4] = ent(16'h0044, 8'h04, 8'h00);
        for (int i = 0; i < 5; i++) exp_q.push_back(i);
        run_walk(1'b0, 2, "R6 overflow error");
        lookup(16'h0011, 8'h01, 1'b0, "R7 blocked after overflow");

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule